// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit, 1024-entry first-in first-out buffer whose producer and consumer run on separate clocks. The clocks may be unrelated or may be the same clock. The producer presents a word and pulls its active-low write strobe. The consumer pulls its active-low read strobe, and the next stored word moves into an output register that holds its value until the next accepted read. A tri-state data bus, gated by an active-low output enable, carries that register out of the block. A select input, when low, parks both strobes. While it is low, the surrounding logic can use the data path for other purposes and no word moves.

The block reports five active-low status flags. Empty and almost-empty belong to the read clock. Full, half-full and almost-full belong to the write clock. The two almost flags compare the fill level with 12-bit threshold inputs. An offset register block outside this one supplies those thresholds. The pointers cross between the clocks as Gray code through two-flop synchronizers. Each flag therefore sees the other side's progress a few of its own clock edges late. The lag always errs towards blocking, never towards overrun or underrun.

Top module: `dcFifoFlags`

## Requirements
- R1: While `rstN` is low, both pointers return to the first entry and the output register clears to zero. On release, `fullN`, `halfFullN` and `almostFullN` read 1 and `emptyN` and `almostEmptyN` read 0.
- R2: On a rising `wrClk` edge with `wrEnN`=0, `offsetSelN`=1 and `fullN`=1, `wrData` is stored. Words come out in the order they went in.
- R3: A write strobe while `fullN` is 0 has no effect. No word is added and nothing already stored is overwritten.
- R4: On a rising `rdClk` edge with `rdEnN`=0, `offsetSelN`=1 and `emptyN`=1, the oldest stored word loads into the output register. A read strobe while `emptyN` is 0 has no effect.
- R5: With no accepted read, the output register keeps its value. A word written into an empty buffer appears on `rdData` only after an explicit read.
- R6: While `offsetSelN` is 0, neither `wrEnN` nor `rdEnN` moves a word or changes a pointer.
- R7: `fullN` changes only on `wrClk` edges. It goes to 0 on the edge that fills the last free entry. It returns to 1 no later than the fourth `wrClk` edge after a read frees an entry.
- R8: `emptyN` changes only on `rdClk` edges. It goes to 0 on the edge that takes the last word. It returns to 1 no later than the fourth `rdClk` edge after a write.
- R9: `halfFullN` is 0 when the write side's fill count exceeds 512 (half the depth).
- R10: `almostFullN` is 0 when the free entries seen by the write side, 1024 minus the fill count, are at or below `fullOffset`, compared as unsigned.
- R11: `almostEmptyN` is 0 when the fill count seen by the read side is at or below `emptyOffset`, compared as unsigned.
- R12: While `outEnN` is 1, `rdData` is high impedance. While `outEnN` is 0, `rdData` carries the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Producer clock |
| rdClk | input | 1 | Consumer clock |
| rstN | input | 1 | Asynchronous reset of both sides, active low |
| wrData | input | 18 | Word to store |
| wrEnN | input | 1 | Write strobe, active low |
| offsetSelN | input | 1 | Low parks both strobes; high for normal traffic |
| rdEnN | input | 1 | Read strobe, active low |
| outEnN | input | 1 | Output bus enable, active low |
| emptyOffset | input | 12 | Threshold for the almost-empty flag |
| fullOffset | input | 12 | Threshold for the almost-full flag |
| rdData | output | 18 | Output register, tri-stated while `outEnN` is high |
| emptyN | output | 1 | No word available, active low, read clock |
| almostEmptyN | output | 1 | Fill at or below the empty threshold, active low, read clock |
| halfFullN | output | 1 | More than half full, active low, write clock |
| almostFullN | output | 1 | Free space at or below the full threshold, active low, write clock |
| fullN | output | 1 | No free entry, active low, write clock |

## Verification
A corrupted pointer or a broken Gray conversion shows up first in the flags. Within five cycles of the affected clock, a flag leaves the window that lies between the true fill count and the count that lagging synchronizers could still be reporting. A wrong array address or a missed strobe shows up on `rdData` at the first read that reaches the affected word. The received word then differs from the head of the reference queue. A write slipped past a full or parked buffer leaves an extra word behind. That word shows up when the buffer is drained and `emptyN` fails to stay low.

// File: rtl/dcFifoPkg.sv
`timescale 1ns/100ps
package dcFifoPkg;

  // Per-cycle commands from the pointer control to the storage path
  typedef struct packed {
    logic wrStb;  // store wrData at wrAddr on this wrClk edge
    logic rdStb;  // load the word at rdAddr on this rdClk edge
  } fifoStb_t;

  // Flag levels right after reset (active low flags)
  localparam logic FULL_N_RST  = 1'b1;
  localparam logic HALF_N_RST  = 1'b1;
  localparam logic AFULL_N_RST = 1'b1;
  localparam logic EMPTY_N_RST = 1'b0;
  localparam logic AEMPT_N_RST = 1'b0;

endpackage

// File: rtl/dcFifoSync.sv
`timescale 1ns/100ps
module dcFifoSync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);

  logic [W-1:0] chain [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : gStage
    if (gi == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[gi] <= '0;
        else       chain[gi] <= dIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[gi] <= '0;
        else       chain[gi] <= chain[gi-1];
      end
    end
  end

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/dcFifoCtrl.sv
`timescale 1ns/100ps
module dcFifoCtrl
  import dcFifoPkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int OFF_W       = 12,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             offsetSelN,
  input  logic [OFF_W-1:0] emptyOffset,
  input  logic [OFF_W-1:0] fullOffset,
  output fifoStb_t         stb,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output logic             fullN,
  output logic             halfFullN,
  output logic             almostFullN,
  output logic             emptyN,
  output logic             almostEmptyN
);

  // Compare width wide enough for both a fill count and an offset
  localparam int CW = ((PW > OFF_W) ? PW : OFF_W) + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write clock domain ----------------
  logic [PW-1:0] wrPtr, wrGray, wrPtrNext, rdGraySyncW, rdPtrW, wrFill;
  logic [CW-1:0] wrFillW, wrFreeW;
  logic          wrGo, fullHit, halfHit, aFullHit;

  dcFifoSync #(.W(PW), .STAGES(SYNC_STAGES)) uRdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .dIn (rdGray),
    .dOut(rdGraySyncW)
  );

  always_comb begin
    wrGo      = !wrEnN && offsetSelN && fullN;
    wrPtrNext = wrPtr + PW'(wrGo);
    rdPtrW    = toBin(rdGraySyncW);
    wrFill    = wrPtrNext - rdPtrW;
    wrFillW   = CW'(wrFill);
    wrFreeW   = CW'(DEPTH) - wrFillW;
    fullHit   = (wrFillW == CW'(DEPTH));
    halfHit   = (wrFillW > CW'(DEPTH / 2));
    aFullHit  = (wrFreeW <= CW'(fullOffset));
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrGray      <= '0;
      fullN       <= FULL_N_RST;
      halfFullN   <= HALF_N_RST;
      almostFullN <= AFULL_N_RST;
    end else begin
      wrPtr       <= wrPtrNext;
      wrGray      <= toGray(wrPtrNext);
      fullN       <= !fullHit;
      halfFullN   <= !halfHit;
      almostFullN <= !aFullHit;
    end
  end

  // ---------------- read clock domain ----------------
  logic [PW-1:0] rdPtr, rdGray, rdPtrNext, wrGraySyncR, wrPtrR, rdFill;
  logic          rdGo, emptyHit, aEmptyHit;

  dcFifoSync #(.W(PW), .STAGES(SYNC_STAGES)) uWrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .dIn (wrGray),
    .dOut(wrGraySyncR)
  );

  always_comb begin
    rdGo      = !rdEnN && offsetSelN && emptyN;
    rdPtrNext = rdPtr + PW'(rdGo);
    wrPtrR    = toBin(wrGraySyncR);
    rdFill    = wrPtrR - rdPtrNext;
    emptyHit  = (rdFill == '0);
    aEmptyHit = (CW'(rdFill) <= CW'(emptyOffset));
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr        <= '0;
      rdGray       <= '0;
      emptyN       <= EMPTY_N_RST;
      almostEmptyN <= AEMPT_N_RST;
    end else begin
      rdPtr        <= rdPtrNext;
      rdGray       <= toGray(rdPtrNext);
      emptyN       <= !emptyHit;
      almostEmptyN <= !aEmptyHit;
    end
  end

  // ---------------- commands to the storage path ----------------
  always_comb begin
    stb.wrStb = wrGo;
    stb.rdStb = rdGo;
  end
  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  // R3
  no_write_when_full_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrPtr));

  // R4
  no_read_when_empty_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdPtr));

  // R6
  parked_write_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !offsetSelN |=> $stable(wrPtr));

  // R9 R10
  full_implies_high_fill_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> (!halfFullN && !almostFullN));

  // R11
  empty_implies_low_fill_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);

endmodule

// File: rtl/dcFifoData.sv
`timescale 1ns/100ps
module dcFifoData
  import dcFifoPkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  fifoStb_t      stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  input  logic          outEnN,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          outReg <= '0;
    else if (stb.rdStb) outReg <= store[rdAddr];
  end

  assign rdData = outEnN ? {DW{1'bz}} : outReg;

  // R5
  hold_output_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdStb |=> $stable(outReg));

endmodule

// File: rtl/dcFifoFlags.sv
`timescale 1ns/100ps
module dcFifoFlags
  import dcFifoPkg::*;
#(
  parameter int DW          = 18,
  parameter int DEPTH       = 1024,
  parameter int OFF_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic [DW-1:0]    wrData,
  input  logic             wrEnN,
  input  logic             offsetSelN,
  input  logic             rdEnN,
  input  logic             outEnN,
  input  logic [OFF_W-1:0] emptyOffset,
  input  logic [OFF_W-1:0] fullOffset,
  output logic [DW-1:0]    rdData,
  output logic             emptyN,
  output logic             almostEmptyN,
  output logic             halfFullN,
  output logic             almostFullN,
  output logic             fullN
);

  localparam int AW = $clog2(DEPTH);

  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  dcFifoCtrl #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .wrEnN       (wrEnN),
    .rdEnN       (rdEnN),
    .offsetSelN  (offsetSelN),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .rdAddr      (rdAddr),
    .fullN       (fullN),
    .halfFullN   (halfFullN),
    .almostFullN (almostFullN),
    .emptyN      (emptyN),
    .almostEmptyN(almostEmptyN)
  );

  dcFifoData #(.DW(DW), .DEPTH(DEPTH)) uData (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .stb   (stb),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .outEnN(outEnN),
    .rdData(rdData)
  );

endmodule

// File: tb/sim_dcFifoFlags.sv
`timescale 1ns/100ps
module sim_dcFifoFlags;

  localparam int DW    = 18;
  localparam int DEPTH = 1024;
  localparam int OFF_W = 12;
  localparam int HIST  = 5;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  always #2   wrClk = ~wrClk;   // 250 MHz
  always #3.5 rdClk = ~rdClk;   // unrelated read clock

  logic             rstN = 1'b0;
  logic [DW-1:0]    wrData = '0;
  logic             wrEnN = 1'b1;
  logic             offsetSelN = 1'b1;
  logic             rdEnN = 1'b1;
  logic             outEnN = 1'b0;
  logic [OFF_W-1:0] emptyOffset = 12'd31;
  logic [OFF_W-1:0] fullOffset = 12'd127;
  wire  [DW-1:0]    rdData;
  wire              emptyN, almostEmptyN, halfFullN, almostFullN, fullN;

  dcFifoFlags #(.DW(DW), .DEPTH(DEPTH), .OFF_W(OFF_W)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrData(wrData), .wrEnN(wrEnN), .offsetSelN(offsetSelN),
    .rdEnN(rdEnN), .outEnN(outEnN),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .rdData(rdData), .emptyN(emptyN), .almostEmptyN(almostEmptyN),
    .halfFullN(halfFullN), .almostFullN(almostFullN), .fullN(fullN)
  );

  int vectors = 0;
  int misses  = 0;
  int wrTotal = 0;
  int rdTotal = 0;
  int wrPct   = 0;
  int rdPct   = 0;
  int rdHist [HIST];
  int wrHist [HIST];
  logic [DW-1:0] model [$];
  logic [DW-1:0] expOut = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // A flag seen through lagging synchronizers: forced low or forced high
  // only when every count it could be using agrees.
  task automatic flagChk(input string req, input string what, input logic flagN,
                         input bit mustLow, input bit mustHigh);
    if (mustLow)  chk(flagN === 1'b0, req, what, longint'(flagN), 0);
    if (mustHigh) chk(flagN === 1'b1, req, what, longint'(flagN), 1);
  endtask

  // Write side: flag checks and stimulus, once per wrClk cycle
  initial begin
    forever begin
      int cTrue, cStale, fOff;
      @(negedge wrClk);
      if (!rstN) begin
        wrEnN   = 1'b1;
        wrTotal = 0;
        model.delete();
        for (int i = 0; i < HIST; i++) rdHist[i] = 0;
      end else begin
        cTrue  = wrTotal - rdTotal;
        cStale = wrTotal - rdHist[HIST-1];
        fOff   = int'(fullOffset);
        flagChk("R7",  "fullN",       fullN,       cTrue == DEPTH,       cStale < DEPTH);
        flagChk("R9",  "halfFullN",   halfFullN,   cTrue > DEPTH / 2,    cStale <= DEPTH / 2);
        flagChk("R10", "almostFullN", almostFullN, DEPTH - cTrue <= fOff, DEPTH - cStale > fOff);
        for (int i = HIST - 1; i > 0; i--) rdHist[i] = rdHist[i-1];
        rdHist[0] = rdTotal;
        wrData = DW'($urandom);
        if (int'($urandom_range(99)) < wrPct) begin
          wrEnN = 1'b0;
          if (fullN === 1'b1 && offsetSelN) begin
            model.push_back(wrData);
            wrTotal++;
          end
        end else begin
          wrEnN = 1'b1;
        end
      end
    end
  end

  // Read side: data, bus and flag checks and stimulus, once per rdClk cycle
  initial begin
    forever begin
      int cTrue, cLow, eOff;
      @(negedge rdClk);
      if (!rstN) begin
        rdEnN   = 1'b1;
        rdTotal = 0;
        expOut  = '0;
        for (int i = 0; i < HIST; i++) wrHist[i] = 0;
      end else begin
        if (!outEnN)
          chk(rdData === expOut, "R2/R4/R5", "rdData", longint'(rdData), longint'(expOut));
        else if (expOut != '0)
          chk(rdData !== expOut, "R12", "rdData while disabled", longint'(rdData), -1);
        cTrue = wrTotal - rdTotal;
        cLow  = wrHist[HIST-1] - rdTotal;
        eOff  = int'(emptyOffset);
        flagChk("R8",  "emptyN",       emptyN,       cTrue == 0,    cLow > 0);
        flagChk("R11", "almostEmptyN", almostEmptyN, cTrue <= eOff, cLow > eOff);
        for (int i = HIST - 1; i > 0; i--) wrHist[i] = wrHist[i-1];
        wrHist[0] = wrTotal;
        if (int'($urandom_range(99)) < rdPct) begin
          rdEnN = 1'b0;
          if (emptyN === 1'b1 && offsetSelN) begin
            if (model.size() == 0) begin
              chk(1'b0, "R4", "read accepted with nothing stored", 1, 0);
            end else begin
              expOut = model.pop_front();
              rdTotal++;
            end
          end
        end else begin
          rdEnN = 1'b1;
        end
      end
    end
  end

  task automatic resetFlagsChk();
    @(negedge wrClk);
    chk(fullN === 1'b1,        "R1", "fullN after reset",        longint'(fullN), 1);
    chk(halfFullN === 1'b1,    "R1", "halfFullN after reset",    longint'(halfFullN), 1);
    chk(almostFullN === 1'b1,  "R1", "almostFullN after reset",  longint'(almostFullN), 1);
    chk(emptyN === 1'b0,       "R1", "emptyN after reset",       longint'(emptyN), 0);
    chk(almostEmptyN === 1'b0, "R1", "almostEmptyN after reset", longint'(almostEmptyN), 0);
    chk(rdData === '0,         "R1", "rdData after reset",       longint'(rdData), 0);
  endtask

  task automatic applyReset(input int eOff, input int fOff);
    wrPct = 0;
    rdPct = 0;
    repeat (10) @(negedge rdClk);
    @(posedge wrClk); #1;
    rstN = 1'b0;
    emptyOffset = OFF_W'(eOff);
    fullOffset  = OFF_W'(fOff);
    repeat (6) @(posedge rdClk);
    @(posedge wrClk); #1;
    rstN = 1'b1;
    resetFlagsChk();
  endtask

  task automatic blankBus(input int cycles);
    @(posedge rdClk); #1;
    outEnN = 1'b1;
    repeat (cycles) @(posedge rdClk);
    #1;
    outEnN = 1'b0;
  endtask

  initial begin
    applyReset(31, 127);

    // R2 R3 R7: fill completely, then keep writing into a full buffer
    wrPct = 100;
    while (wrTotal < DEPTH) @(negedge wrClk);
    repeat (40) @(negedge wrClk);
    wrPct = 0;
    repeat (10) @(negedge wrClk);
    chk(fullN === 1'b0, "R7", "fullN held while full", longint'(fullN), 0);
    chk(wrTotal == DEPTH, "R3", "accepted writes", wrTotal, DEPTH);

    // R4 R8: drain everything; no stray word may follow
    rdPct = 100;
    while (rdTotal < wrTotal) @(negedge rdClk);
    repeat (20) @(negedge rdClk);
    rdPct = 0;
    repeat (4) @(negedge rdClk);
    chk(emptyN === 1'b0, "R3", "empty after draining a full buffer", longint'(emptyN), 0);

    // R6: strobes parked
    offsetSelN = 1'b0;
    wrPct = 100;
    rdPct = 100;
    repeat (60) @(negedge wrClk);
    wrPct = 0;
    rdPct = 0;
    repeat (10) @(negedge rdClk);
    chk(emptyN === 1'b0, "R6", "emptyN after parked writes", longint'(emptyN), 0);
    chk(wrTotal == rdTotal, "R6", "words moved while parked", wrTotal - rdTotal, 0);
    offsetSelN = 1'b1;
    repeat (4) @(negedge wrClk);

    // R5: one word into an empty buffer stays hidden until read
    wrPct = 100;
    @(negedge wrClk);
    wrPct = 0;
    repeat (12) @(negedge rdClk);
    chk(emptyN === 1'b1, "R8", "emptyN after single write", longint'(emptyN), 1);
    rdPct = 100;
    repeat (3) @(negedge rdClk);
    rdPct = 0;

    // Mixed traffic, filling then draining, with bus blanking (R12)
    wrPct = 60; rdPct = 70;
    repeat (3000) @(negedge wrClk);
    blankBus(15);
    wrPct = 25; rdPct = 95;
    repeat (3000) @(negedge wrClk);
    blankBus(10);

    // Second threshold setting
    applyReset(600, 900);
    wrPct = 75; rdPct = 50;
    repeat (4000) @(negedge wrClk);
    wrPct = 20; rdPct = 95;
    repeat (4000) @(negedge wrClk);
    wrPct = 0;
    rdPct = 100;
    while (rdTotal < wrTotal) @(negedge rdClk);
    repeat (10) @(negedge rdClk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wrClk);
    misses++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule